// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block drives a single open-drain data line for a one-wire serial bus. It pulls the line low by raising an output-enable and lets it float by dropping it. The host asks for one bit-level operation at a time: a bus reset with presence detection, a write-0 slot, a write-1 slot, or a read slot. The block answers with a one-cycle completion strobe, a presence flag or a read bit, and a busy flag. It does nothing at the byte or command level.

All timing is counted in ticks of a clock-enable input with a period of one microsecond. A mode input selects standard or overdrive timing. The mode and the operation are captured when a request is accepted. Every slot includes its recovery gap before completion is reported, so a host may issue requests back to back without timing of its own.

Requests use a valid/ready handshake. `req_ready` is high exactly when the block is idle. A request offered while `req_ready` is low is not taken. The host keeps `req_valid` and `req_op` steady until a cycle in which both valid and ready are high. The results side has no back-pressure: `done` is a plain strobe, and the result flags hold their value until the next completion.

Top module: `owire_master`

## Requirements
- R1: Operation code 0 (bus reset) drives the line low for 480 ticks in standard mode or 70 ticks in overdrive mode, then releases it.
- R2: An accepted request raises `busy` and `line_oe` in the cycle after acceptance, so every slot begins with a falling edge.
- R3: Operation code 1 (write-0) holds the line low for the full slot: 65 ticks in standard mode, 8 in overdrive.
- R4: Operation code 2 (write-1) releases the line after 6 ticks in standard mode or 1 tick in overdrive, inside the 15 and 2 microsecond limits.
- R5: Operation code 3 (read) holds the line low for 1 tick, samples the line 13 ticks (standard) or 2 ticks (overdrive) after the slot start, and reports the sampled level on `rd_bit`.
- R6: A bus reset samples the line 70 ticks (standard) or 9 ticks (overdrive) after release. `presence` is 1 if the line was low there and 0 otherwise. The reset completes 410 or 40 ticks after that sample.
- R7: `req_ready` equals the inverse of `busy`. A request offered while busy is neither taken nor alters the running operation, and `busy` rises only after a request.
- R8: Slots complete after slot time plus recovery: 70 ticks standard, 10 ticks overdrive. The line is released during recovery and whenever the block is idle.
- R9: `done` is a single-cycle pulse in the cycle `busy` falls. `presence` and `rd_bit` change only in that cycle. After reset, `busy`, `done`, `line_oe`, `presence` and `rd_bit` are 0.
- R10: A change of `overdrive` while an operation runs has no effect on that operation's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| overdrive | input | 1 | 1 selects overdrive timing, captured at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request (idle) |
| req_op | input | 2 | 0 reset, 1 write-0, 2 write-1, 3 read |
| done | output | 1 | One-cycle completion strobe |
| presence | output | 1 | Presence seen by the last bus reset |
| rd_bit | output | 1 | Level sampled by the last read slot |
| busy | output | 1 | Operation in progress |
| line_in | input | 1 | Level of the bus line |
| line_oe | output | 1 | 1 pulls the line low |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. `busy` drops together with `done`, so a request already held valid is taken in that very cycle. The bench keeps `req_valid` high across the end of an overdrive write-0. It checks that `done`, `req_ready` and `req_valid` are all high together. It then checks that the next cycle shows `busy` and `line_oe` high again, and that the first slot still used its full slot-plus-recovery length. Two other collisions are also provoked. A second request is offered mid-slot to show the handshake refuses it. The mode input is flipped mid-slot to show the captured mode keeps control.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_BUSRST = 2'd0,
    OP_WR0    = 2'd1,
    OP_WR1    = 2'd2,
    OP_READ   = 2'd3
  } owm_op_e;
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/owm_timing.sv
module owm_timing
  import owm_pkg::*;
#(
  parameter int TW          = 11,
  parameter int S_RST_LOW   = 480,
  parameter int S_PRES_WAIT = 70,
  parameter int S_RST_TAIL  = 410,
  parameter int S_SLOT      = 65,
  parameter int S_W1_LOW    = 6,
  parameter int S_RD_LOW    = 1,
  parameter int S_RD_SAMP   = 13,
  parameter int S_REC       = 5,
  parameter int O_RST_LOW   = 70,
  parameter int O_PRES_WAIT = 9,
  parameter int O_RST_TAIL  = 40,
  parameter int O_SLOT      = 8,
  parameter int O_W1_LOW    = 1,
  parameter int O_RD_LOW    = 1,
  parameter int O_RD_SAMP   = 2,
  parameter int O_REC       = 2
) (
  input  owm_op_e         op,
  input  logic            od,
  output logic [TW-1:0]   low_len,
  output logic [TW-1:0]   samp_pt,
  output logic [TW-1:0]   end_pt,
  output logic            has_samp
);
  localparam int NMODE = 2;
  localparam int RST_LOW  [NMODE] = '{S_RST_LOW, O_RST_LOW};
  localparam int PRES_WT  [NMODE] = '{S_PRES_WAIT, O_PRES_WAIT};
  localparam int RST_TAIL [NMODE] = '{S_RST_TAIL, O_RST_TAIL};
  localparam int SLOT     [NMODE] = '{S_SLOT, O_SLOT};
  localparam int W1_LOW   [NMODE] = '{S_W1_LOW, O_W1_LOW};
  localparam int RD_LOW   [NMODE] = '{S_RD_LOW, O_RD_LOW};
  localparam int RD_SAMP  [NMODE] = '{S_RD_SAMP, O_RD_SAMP};
  localparam int REC      [NMODE] = '{S_REC, O_REC};

  logic [TW-1:0] t_rlow  [NMODE];
  logic [TW-1:0] t_psamp [NMODE];
  logic [TW-1:0] t_rend  [NMODE];
  logic [TW-1:0] t_slot  [NMODE];
  logic [TW-1:0] t_w1    [NMODE];
  logic [TW-1:0] t_rdl   [NMODE];
  logic [TW-1:0] t_rds   [NMODE];
  logic [TW-1:0] t_send  [NMODE];

  generate
    for (genvar m = 0; m < NMODE; m++) begin : g_mode
      assign t_rlow[m]  = TW'(RST_LOW[m]);
      assign t_psamp[m] = TW'(RST_LOW[m] + PRES_WT[m]);
      assign t_rend[m]  = TW'(RST_LOW[m] + PRES_WT[m] + RST_TAIL[m]);
      assign t_slot[m]  = TW'(SLOT[m]);
      assign t_w1[m]    = TW'(W1_LOW[m]);
      assign t_rdl[m]   = TW'(RD_LOW[m]);
      assign t_rds[m]   = TW'(RD_SAMP[m]);
      assign t_send[m]  = TW'(SLOT[m] + REC[m]);
    end
  endgenerate

  logic mi;
  assign mi = od;

  always_comb begin
    low_len  = t_slot[mi];
    samp_pt  = '0;
    end_pt   = t_send[mi];
    has_samp = 1'b0;
    unique case (op)
      OP_BUSRST: begin
        low_len  = t_rlow[mi];
        samp_pt  = t_psamp[mi];
        end_pt   = t_rend[mi];
        has_samp = 1'b1;
      end
      OP_WR0: low_len = t_slot[mi];
      OP_WR1: low_len = t_w1[mi];
      OP_READ: begin
        low_len  = t_rdl[mi];
        samp_pt  = t_rds[mi];
        has_samp = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          od_in,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          line_s,
  input  logic [TW-1:0] low_len,
  input  logic [TW-1:0] samp_pt,
  input  logic [TW-1:0] end_pt,
  input  logic          has_samp,
  output owm_op_e       op_q,
  output logic          od_q,
  output logic          busy,
  output logic          done,
  output logic          line_oe,
  output logic          presence,
  output logic          rd_bit
);
  logic [TW-1:0] elapsed;
  logic [TW-1:0] nxt;
  logic          smp;
  logic          accept;
  logic          at_samp;
  logic          at_end;

  assign accept  = req_valid && !busy;
  assign nxt     = elapsed + 1'b1;
  assign at_samp = has_samp && (nxt == samp_pt);
  assign at_end  = (nxt == end_pt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      line_oe  <= 1'b0;
      elapsed  <= '0;
      op_q     <= OP_BUSRST;
      od_q     <= 1'b0;
      smp      <= 1'b1;
      presence <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        line_oe <= 1'b1;
        elapsed <= '0;
        op_q    <= owm_op_e'(req_op);
        od_q    <= od_in;
        smp     <= 1'b1;
      end else if (busy && tick) begin
        elapsed <= nxt;
        line_oe <= (nxt < low_len);
        if (at_samp) smp <= line_s;
        if (at_end) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          line_oe <= 1'b0;
          if (op_q == OP_BUSRST) presence <= !smp;
          if (op_q == OP_READ)   rd_bit   <= smp;
        end
      end
    end
  end
endmodule

// File: rtl/owire_master.sv
module owire_master
  import owm_pkg::*;
#(
  parameter int TW          = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       overdrive,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  output logic       busy,
  input  logic       line_in,
  output logic       line_oe
);
  owm_op_e       op_q;
  logic          od_q;
  logic          line_s;
  logic [TW-1:0] low_len;
  logic [TW-1:0] samp_pt;
  logic [TW-1:0] end_pt;
  logic          has_samp;

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  owm_timing #(.TW(TW)) u_time (
    .op(op_q), .od(od_q), .low_len(low_len), .samp_pt(samp_pt),
    .end_pt(end_pt), .has_samp(has_samp)
  );

  owm_engine #(.TW(TW)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .od_in(overdrive),
    .req_valid(req_valid), .req_op(req_op), .line_s(line_s),
    .low_len(low_len), .samp_pt(samp_pt), .end_pt(end_pt),
    .has_samp(has_samp), .op_q(op_q), .od_q(od_q), .busy(busy),
    .done(done), .line_oe(line_oe), .presence(presence), .rd_bit(rd_bit)
  );

  assign req_ready = !busy;
endmodule

// File: rtl/owm_checker.sv
module owm_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic line_oe,
  input logic presence,
  input logic rd_bit
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && line_oe)); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe); // R8
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(presence) && $stable(rd_bit))); // R9
endmodule

bind owire_master owm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .line_oe(line_oe), .presence(presence),
  .rd_bit(rd_bit)
);

// File: tb/sim_owire_master.sv
`timescale 1ns/1ps
module sim_owire_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic       overdrive = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic       done, presence, rd_bit, busy, line_oe;
  logic       slave_pull = 1'b0;
  logic       line_in;
  int         errors = 0;
  int         checks = 0;
  logic [1:0] tdiv = 2'd0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    tick_us <= (tdiv == 2'd3);
  end

  assign line_in = !(line_oe || slave_pull);

  owire_master u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .overdrive(overdrive),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .done(done), .presence(presence), .rd_bit(rd_bit), .busy(busy),
    .line_in(line_in), .line_oe(line_oe)
  );

  typedef struct packed {
    logic [1:0] op;
    logic       od;
    int         a;
    int         b;
    int         low;
    int         tot;
    logic       flag;
    logic       chkf;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 495, 615, 480, 960, 1'b1, 1'b1},
    '{2'd0, 1'b0,   0,   0, 480, 960, 1'b0, 1'b1},
    '{2'd0, 1'b1,  72,  86,  70, 119, 1'b1, 1'b1},
    '{2'd0, 1'b1,   0,   0,  70, 119, 1'b0, 1'b1},
    '{2'd1, 1'b0,   0,   0,  65,  70, 1'b0, 1'b0},
    '{2'd2, 1'b0,   0,   0,   6,  70, 1'b0, 1'b0},
    '{2'd3, 1'b0,   1,  40,   1,  70, 1'b0, 1'b1},
    '{2'd3, 1'b0,   0,   0,   1,  70, 1'b1, 1'b1},
    '{2'd1, 1'b1,   0,   0,   8,  10, 1'b0, 1'b0},
    '{2'd2, 1'b1,   0,   0,   1,  10, 1'b0, 1'b0},
    '{2'd3, 1'b1,   1,   5,   1,  10, 1'b0, 1'b1},
    '{2'd3, 1'b1,   0,   0,   1,  10, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic od, input int a, input int b,
                        input int poke_at, input int flip_at,
                        output int lowt, output int total, output logic flag,
                        output logic dn, output logic poke_rdy);
    int tcnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; overdrive = od; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    tcnt = 0; lowt = 0; poke_rdy = 1'b0;
    while (busy) begin
      if (tick_us && line_oe) lowt++;
      if (tick_us) tcnt++;
      slave_pull = (tcnt >= a) && (tcnt < b);
      if (tcnt == flip_at) overdrive = !od;
      if (tcnt == poke_at && !req_valid) begin
        req_valid = 1'b1; req_op = 2'd3; poke_rdy = req_ready;
      end else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    slave_pull = 1'b0;
    total = tcnt;
    dn = done;
    flag = (op == 2'd3) ? rd_bit : presence;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int lowt, total, t1;
    logic flag, dn, prdy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 R8 R7: reset state
    chk(!busy && !done && !line_oe, "R9 reset outputs", {busy, done, line_oe}, 0);
    chk(!presence && !rd_bit, "R9 reset flags", {presence, rd_bit}, 0);
    chk(req_ready, "R7 ready when idle", req_ready, 1);

    // Table: R1 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].op, VECS[i].od, VECS[i].a, VECS[i].b, -1, -1, lowt, total, flag, dn, prdy);
      chk(lowt == VECS[i].low, "R1/R3/R4/R5 low ticks", lowt, VECS[i].low);
      chk(total == VECS[i].tot, "R6/R8 total ticks", total, VECS[i].tot);
      chk(dn, "R9 done at busy fall", dn, 1);
      if (VECS[i].chkf)
        chk(flag == VECS[i].flag, "R5/R6 sampled flag", flag, VECS[i].flag);
    end

    // R7: request while busy is refused and has no effect
    run_op(2'd1, 1'b0, 0, 0, 10, -1, lowt, total, flag, dn, prdy);
    chk(!prdy, "R7 ready low while busy", prdy, 0);
    chk(lowt == 65 && total == 70, "R7 running write-0 unchanged", total, 70);
    repeat (40) @(negedge clk);
    chk(!busy && !line_oe, "R7 refused request not started", busy, 0);

    // R10: mode flipped mid-operation
    run_op(2'd2, 1'b0, 0, 0, -1, 3, lowt, total, flag, dn, prdy);
    chk(lowt == 6 && total == 70, "R10 write-1 keeps standard timing", total, 70);
    run_op(2'd0, 1'b0, 0, 0, -1, 100, lowt, total, flag, dn, prdy);
    chk(lowt == 480 && total == 960, "R10 reset keeps standard timing", total, 960);
    run_op(2'd0, 1'b0, 495, 615, -1, -1, lowt, total, flag, dn, prdy);
    run_op(2'd3, 1'b0, 0, 0, -1, -1, lowt, total, flag, dn, prdy);
    chk(presence == 1'b1, "R9 presence held across read", presence, 1);

    // R2 R8: completion and next acceptance in the same cycle
    @(negedge clk);
    overdrive = 1'b1; req_op = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    t1 = 0;
    while (!done) begin
      if (tick_us) t1++;
      @(negedge clk);
    end
    chk(done && req_ready && req_valid, "R8 done with ready and valid", {done, req_ready}, 3);
    chk(t1 == 10, "R8 overdrive slot plus recovery", t1, 10);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && line_oe, "R2 back-to-back slot starts low", {busy, line_oe}, 3);
    t1 = 0;
    while (!done) begin
      if (tick_us) t1++;
      @(negedge clk);
    end
    chk(t1 == 10, "R8 second slot length", t1, 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule